// File: doc/BRIEF.md
# Ripple-Through Marker FIFO

This block is a first-in first-out buffer of 16 four-bit words, organised as a chain of register stages, not as a RAM with read and write pointers. Each stage holds one word and a marker bit that says whether the word is valid. A marked word moves one stage toward the output on every clock in which the stage ahead of it is empty. An entered word therefore falls through an empty buffer to the output end on its own, and words already waiting stack up behind the output stage.

The writer raises `shift_in` while `in_ready` is high to enter the word on `din`. The reader watches `out_ready`, reads `dout`, and drops `shift_out` to discard that word. The next word then ripples forward. Both strobes are sampled on the system clock and their edges are detected inside the block, so a strobe held at one level acts only once.

`out_disable` turns off the data outputs, modelled as an enable output plus a bus that reads zero, and it blocks unloading. The asynchronous active-low reset clears every marker but leaves the stored data untouched; the old words are simply no longer valid. Two instances chain by feeding `out_ready` of one into `shift_in` of the next, and `in_ready` of the next back into `shift_out` of the first.

Top module: `ripple_fifo`

## Requirements
- R1: From reset until a word is accepted, `in_ready` is 1 and `out_ready` is 0. Reset clears every marker. It becomes inactive two clocks after `rst_n` is released.
- R2: A word is accepted when the clock samples `shift_in` high after sampling it low on the previous clock while `in_ready` is 1. `din` is stored at that edge, and `in_ready` is 0 in the following cycle.
- R3: A rising edge on `shift_in` while `in_ready` is 0 is ignored. No word is entered, and the edge does not count later when space frees up.
- R4: A marked word moves one stage per clock whenever the next marker is clear. With the buffer empty, `out_ready` rises exactly 15 clocks after the accepting edge.
- R5: Words leave in the order they were accepted. While `out_ready` is 1 and no unload occurs, `dout` holds the oldest unread word.
- R6: A falling edge on `shift_out`, meaning the clock samples it low after sampling it high, unloads the word when `out_ready` is 1 and `out_disable` is 0. `out_ready` is then 0 for one cycle. If the stage behind the output held a word, `out_ready` is 1 again on the next clock.
- R7: When the buffer is empty, falling edges on `shift_out` have no effect. `out_ready` stays 0 until a marked word reaches the last stage.
- R8: While `out_disable` is 1, `dout_drive` is 0, `dout` reads all zeros and no word is unloaded. A `shift_out` falling edge seen during that time is discarded, not deferred.
- R9: The buffer holds 16 words. After 16 accepted words and no unloads, `in_ready` stays 0.
- R10: A reset applied with words stored invalidates them all. None of them is delivered afterwards, and the next accepted word is the next one out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears markers only |
| shift_in | input | 1 | Load strobe, acts on its rising edge |
| din | input | 4 | Word to be entered |
| in_ready | output | 1 | First stage empty, a word may be entered |
| shift_out | input | 1 | Unload strobe, acts on its falling edge |
| out_disable | input | 1 | High turns data outputs off and blocks unloading |
| out_ready | output | 1 | A valid word sits in the last stage |
| dout | output | 4 | Word in the last stage, zero while disabled |
| dout_drive | output | 1 | Output enable of the modelled tri-state bus |

## Verification
The assertions assume that `shift_in` is low while reset is active. They also assume that each strobe level lasts at least one clock, so that a sampled edge stands for one intended action. The bench holds `shift_in` low across both resets. It changes every strobe only on the falling clock edge and holds it for at least a full cycle. `out_disable` is lowered only while `shift_out` is high, so the edge that R8 discards is produced on purpose and never by an accidental level change.

// File: rtl/ripple_fifo_pkg.sv
package ripple_fifo_pkg;
  localparam int unsigned DEF_DEPTH   = 16;
  localparam int unsigned DEF_WIDTH   = 4;
  localparam int unsigned SYNC_FLOPS  = 2;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_kind_t;
endpackage

// File: rtl/rf_reset_sync.sv
module rf_reset_sync #(
  parameter int unsigned FLOPS = ripple_fifo_pkg::SYNC_FLOPS
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [FLOPS-1:0] sync_q;
  logic [FLOPS-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[FLOPS-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[FLOPS-1];
endmodule

// File: rtl/rf_strobe_edge.sv
module rf_strobe_edge
  import ripple_fifo_pkg::*;
#(
  parameter edge_kind_t KIND       = EDGE_RISE,
  parameter logic       IDLE_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic level_i,
  output logic pulse_o
);
  logic level_q;
  logic level_d;

  always_comb begin
    level_d = level_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) level_q <= IDLE_LEVEL;
    else         level_q <= level_d;
  end

  generate
    if (KIND == EDGE_RISE) begin : g_rise
      assign pulse_o = level_i & ~level_q;
    end else begin : g_fall
      assign pulse_o = ~level_i & level_q;
    end
  endgenerate
endmodule

// File: rtl/rf_stage.sv
module rf_stage #(
  parameter int unsigned WIDTH = ripple_fifo_pkg::DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             fill_i,
  input  logic             vacate_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] data_o
);
  logic             valid_q;
  logic             valid_d;
  logic [WIDTH-1:0] data_q;

  always_comb begin
    valid_d = (valid_q & ~vacate_i) | fill_i;
  end

  // marker: cleared by reset
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= valid_d;
  end

  // payload: no reset, explicit clock enable
  always_ff @(posedge clk) begin
    if (fill_i) data_q <= data_i;
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;

  // R5
  stage_no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    fill_i |-> (!valid_q || vacate_i));

  // R4
  stage_vacate_valid_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    vacate_i |-> valid_q);
endmodule

// File: rtl/ripple_fifo.sv
module ripple_fifo
  import ripple_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = DEF_DEPTH,
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_in,
  input  logic [WIDTH-1:0] din,
  output logic             in_ready,
  input  logic             shift_out,
  input  logic             out_disable,
  output logic             out_ready,
  output logic [WIDTH-1:0] dout,
  output logic             dout_drive
);
  localparam int unsigned LAST = DEPTH - 1;

  logic             rst_s;
  logic             si_pulse;
  logic             so_pulse;
  logic             load;
  logic             unload;
  logic [DEPTH-1:0] mark;
  logic [DEPTH-1:0] fill;
  logic [DEPTH-1:0] vacate;
  logic [WIDTH-1:0] word [DEPTH];
  logic [WIDTH-1:0] src  [DEPTH];

  rf_reset_sync #(.FLOPS(SYNC_FLOPS)) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_s)
  );

  rf_strobe_edge #(.KIND(EDGE_RISE), .IDLE_LEVEL(1'b0)) u_si_edge (
    .clk     (clk),
    .rst_ni  (rst_s),
    .level_i (shift_in),
    .pulse_o (si_pulse)
  );

  rf_strobe_edge #(.KIND(EDGE_FALL), .IDLE_LEVEL(1'b0)) u_so_edge (
    .clk     (clk),
    .rst_ni  (rst_s),
    .level_i (shift_out),
    .pulse_o (so_pulse)
  );

  always_comb begin
    load   = rst_s & si_pulse & ~mark[0];
    unload = so_pulse & mark[LAST] & ~out_disable;
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_head
        assign fill[i] = load;
        assign src[i]  = din;
      end else begin : g_body
        assign fill[i] = vacate[i-1];
        assign src[i]  = word[i-1];
      end

      if (i == LAST) begin : g_tail
        assign vacate[i] = unload;
      end else begin : g_move
        assign vacate[i] = mark[i] & ~mark[i+1];

        // R4
        advance_chk: assert property (@(posedge clk) disable iff (!rst_s)
          (mark[i] && !mark[i+1]) |=> mark[i+1]);

        // R4
        hold_blocked_chk: assert property (@(posedge clk) disable iff (!rst_s)
          (mark[i] && mark[i+1]) |=> mark[i]);
      end

      rf_stage #(.WIDTH(WIDTH)) u_stage (
        .clk      (clk),
        .rst_ni   (rst_s),
        .fill_i   (fill[i]),
        .vacate_i (vacate[i]),
        .data_i   (src[i]),
        .valid_o  (mark[i]),
        .data_o   (word[i])
      );
    end
  endgenerate

  assign in_ready   = ~mark[0];
  assign out_ready  = mark[LAST];
  assign dout_drive = ~out_disable;
  assign dout       = out_disable ? '0 : word[LAST];

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (si_pulse && in_ready) |=> !in_ready);

  // R3
  reject_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (si_pulse && mark[0] && mark[1]) |=> $stable(word[0]));

  // R6
  pop_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (so_pulse && out_ready && !out_disable) |=> !out_ready);

  // R8
  inhibit_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (out_disable && out_ready) |=> out_ready);

  // R5
  head_stable_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (out_ready && !(so_pulse && !out_disable)) |=> (out_ready && $stable(word[LAST])));

  // R7
  empty_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (!out_ready && !mark[LAST-1]) |=> !out_ready);
endmodule

// File: tb/tb_ripple_fifo.sv
`timescale 1ns/1ps
module tb_ripple_fifo;
  localparam int unsigned W = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         shift_in;
  logic [W-1:0] din;
  logic         in_ready;
  logic         shift_out;
  logic         out_disable;
  logic         out_ready;
  logic [W-1:0] dout;
  logic         dout_drive;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [W-1:0] exp_q [$];

  always #10 clk = ~clk;

  ripple_fifo dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .shift_in    (shift_in),
    .din         (din),
    .in_ready    (in_ready),
    .shift_out   (shift_out),
    .out_disable (out_disable),
    .out_ready   (out_ready),
    .dout        (dout),
    .dout_drive  (dout_drive)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic do_reset();
    shift_in = 1'b0;
    rst_n    = 1'b0;
    wait_neg(4);
    rst_n    = 1'b1;
    wait_neg(4);
  endtask

  // driver: enters a word once space exists and records it as expected
  task automatic push_word(input logic [W-1:0] w);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    din      = w;
    shift_in = 1'b1;
    exp_q.push_back(w);
    @(negedge clk);
    shift_in = 1'b0;
  endtask

  // monitor: waits for a ready word, compares with scoreboard, unloads it
  task automatic pop_word(input string req);
    logic [W-1:0] e;
    @(negedge clk);
    while (!out_ready) @(negedge clk);
    e = exp_q.pop_front();
    check(dout == e, req, int'(dout), int'(e));
    shift_out = 1'b0;
    @(negedge clk);
    shift_out = 1'b1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    din = '0; shift_out = 1'b1; out_disable = 1'b0; shift_in = 1'b0;
    do_reset();
    // R1
    check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    check(out_ready == 1'b0, "R1 out_ready", int'(out_ready), 0);

    // R2 / R4: single word latency through an empty buffer
    @(negedge clk);
    din = 4'hA; shift_in = 1'b1;
    @(negedge clk);
    shift_in = 1'b0;
    check(in_ready == 1'b0, "R2 in_ready after accept", int'(in_ready), 0);
    wait_neg(14);
    check(out_ready == 1'b0, "R4 not yet at output", int'(out_ready), 0);
    wait_neg(1);
    check(out_ready == 1'b1, "R4 arrival after 15 clocks", int'(out_ready), 1);
    check(dout == 4'hA, "R5 head word", int'(dout), 10);
    shift_out = 1'b0;
    @(negedge clk);
    shift_out = 1'b1;
    check(out_ready == 1'b0, "R6 drop after unload", int'(out_ready), 0);

    // R7: falls on an empty buffer
    for (int k = 0; k < 3; k++) begin
      shift_out = 1'b0; wait_neg(2);
      shift_out = 1'b1; wait_neg(2);
    end
    check(out_ready == 1'b0, "R7 empty stays empty", int'(out_ready), 0);
    push_word(4'h5);
    pop_word("R7 word after empty falls");

    // R9 / R3: fill to capacity, then an ignored strobe
    for (int k = 0; k < 16; k++) push_word(W'(k + 1));
    wait_neg(20);
    check(in_ready == 1'b0, "R9 full", int'(in_ready), 0);
    din = 4'hF; shift_in = 1'b1; wait_neg(2); shift_in = 1'b0;
    wait_neg(4);
    // R6: one-cycle dip when the next stage is occupied
    check(dout == exp_q[0], "R5 full head", int'(dout), int'(exp_q[0]));
    void'(exp_q.pop_front());
    shift_out = 1'b0;
    @(negedge clk);
    shift_out = 1'b1;
    check(out_ready == 1'b0, "R6 dip", int'(out_ready), 0);
    @(negedge clk);
    check(out_ready == 1'b1, "R6 refill next clock", int'(out_ready), 1);
    for (int k = 0; k < 15; k++) pop_word("R5 order after full");
    wait_neg(20);
    check(out_ready == 1'b0, "R3 rejected word absent", int'(out_ready), 0);

    // R8: disable blocks unload and blanks the bus
    push_word(4'h9);
    wait_neg(20);
    out_disable = 1'b1;
    @(negedge clk);
    check(dout_drive == 1'b0, "R8 drive off", int'(dout_drive), 0);
    check(dout == 4'h0, "R8 bus zero", int'(dout), 0);
    shift_out = 1'b0; wait_neg(2); shift_out = 1'b1; wait_neg(2);
    check(out_ready == 1'b1, "R8 unload inhibited", int'(out_ready), 1);
    out_disable = 1'b0;
    wait_neg(2);
    check(out_ready == 1'b1, "R8 fall not deferred", int'(out_ready), 1);
    check(dout_drive == 1'b1, "R8 drive on", int'(dout_drive), 1);
    pop_word("R8 word kept");

    // R5: concurrent driver and monitor
    fork
      for (int k = 0; k < 24; k++) push_word(W'((k * 7 + 3) % 16));
      for (int k = 0; k < 24; k++) pop_word("R5 streaming order");
    join

    // R10: reset with stored words
    push_word(4'h1); push_word(4'h2); push_word(4'h3);
    wait_neg(20);
    do_reset();
    exp_q.delete();
    check(in_ready == 1'b1, "R10 in_ready after reset", int'(in_ready), 1);
    wait_neg(20);
    check(out_ready == 1'b0, "R10 old words invalid", int'(out_ready), 0);
    push_word(4'hC);
    pop_word("R10 first word after reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule